// File: doc/BRIEF.md
# Bridge Power-State and Reset Controller

This block manages the power state and the reset behaviour of a two-port bus bridge. Software writes a 2-bit power-state field. The block keeps only the full-power state and the hot low-power state, and it drops any request for the two intermediate states. When the bridge enters the low-power state and a board strap allows it, every secondary clock output is stopped low. Each stop and each restart is timed so that it lands while that clock is in its low phase. When software brings the bridge back to full power, the block restarts the secondary clocks and raises a fixed-length internal reset pulse. That pulse returns the rest of the chip to its defaults and clears its buffers, and it never drives the secondary bus reset.

The block also handles the asynchronous primary reset input. While that input is low, the bus output-enable is removed at once, so every bus output goes to high impedance. All state returns to its defaults at the same moment. The release of the reset passes through a two-flop synchronizer. A hold-off counter then keeps configuration access closed for a set number of primary clocks before the ready flag goes high.

Top module: `brg_pwr_rst_ctrl`

## Requirements
- R1: The power-state field uses 00 = full power, 01 = light sleep, 10 = deep sleep and 11 = hot low-power. `pstate_o` reports the current state. A write of 01 or 10 leaves `pstate_o` unchanged, whichever state the bridge is in.
- R2: An accepted write of 11 in state 00 moves `pstate_o` to 11 at the clock edge that samples the write. An accepted write of 00 in state 11 moves it to 00 in the same way. Any other write leaves the state unchanged.
- R3: Take the first clock edge after the state has become 11 at which a clock's phase-low input is 1. If the strap `clk_stop_en_i` is 1 at that edge, that clock's enable goes to 0. If the strap is 0, every enable stays 1 while the bridge is in state 11.
- R4: A secondary clock enable changes only at a clock edge where the matching bit of `sec_clk_lo_i` is 1.
- R5: A wake write (00 while in state 11) raises `int_rst_o` for exactly WAKE_LEN (default 4) clock cycles, starting at the edge that samples the write. Each secondary clock enable returns to 1 at the first later edge where its phase-low input is 1.
- R6: `int_rst_o` never occurs together with `sec_bus_rst_o`. The secondary bus reset is driven only by the primary reset.
- R7: While `prst_ni` is 0, `bus_oe_o` is 0 and `sec_bus_rst_o` is 1 without waiting for a clock edge. At the same time `pstate_o` returns to 00, every clock enable returns to 1 and `cfg_ready_o` returns to 0.
- R8: Take a release of `prst_ni` that falls between two clock edges. `cfg_ready_o` rises at the 18th rising edge after that release: two synchronizer stages plus HOLDOFF (default 16) hold-off cycles. Writes before that edge have no effect.
- R9: Writes sampled while `int_rst_o` is 1 have no effect on the power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Primary clock |
| prst_ni | input | 1 | Primary reset, active low, asynchronous |
| clk_stop_en_i | input | 1 | Strap allowing the secondary clocks to stop in low-power state |
| sec_clk_lo_i | input | NUM_SEC_CLK | Per secondary clock: 1 while that clock is in its low phase |
| cfg_wr_i | input | 1 | Power-state write strobe |
| cfg_wdata_i | input | 2 | Requested power-state code |
| pstate_o | output | 2 | Current power-state code |
| sec_clk_en_o | output | NUM_SEC_CLK | Secondary clock enables (0 = held low) |
| bus_oe_o | output | 1 | Bus output enable (0 = all bus outputs high impedance) |
| sec_bus_rst_o | output | 1 | Secondary bus reset, active high |
| int_rst_o | output | 1 | Internal wake reset pulse, active high |
| cfg_ready_o | output | 1 | Configuration accesses are accepted |

## Verification
Directed sequences cover each of the four codes written in each implemented state. They separate the two accepted transitions from the ignored ones, and they show that unimplemented codes are rejected in the low-power state as well as in full power. The strap is tried at both levels, and the phase-low inputs are held at 0 on one clock only. Together these show that the stop follows the strap and that each clock is gated on its own phase. A write inside the wake pulse and a write held through the hold-off window show the two windows in which writes are locked out. A long random phase then mixes writes, strap changes and phase patterns against a cycle model of state, pulse and enables.

// File: rtl/brg_pwr_pkg.sv
package brg_pwr_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_e;

    function automatic logic is_sleep(input pstate_e st);
        return st == PS_D3HOT;
    endfunction

endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    output logic rst_no
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = 1'b1;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q <= '0;
        else          sync_q <= sync_d;
    end

    assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/brg_holdoff.sv
module brg_holdoff #(
    parameter int HOLDOFF = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ready_o
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/brg_pstate_fsm.sv
module brg_pstate_fsm
    import brg_pwr_pkg::*;
#(
    parameter int WAKE_LEN = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ready_i,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output pstate_e    pstate_o,
    output logic       wake_rst_o
);
    localparam int WW = $clog2(WAKE_LEN + 1);
    localparam logic [WW-1:0] WLEN = WW'(WAKE_LEN);

    typedef struct packed {
        pstate_e       st;
        logic [WW-1:0] wcnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    pstate_e req;
    logic    accept;

    always_comb begin
        fsm_d  = fsm_q;
        req    = pstate_e'(wdata_i);
        accept = wr_i && ready_i && (fsm_q.wcnt == '0);
        if (fsm_q.wcnt != '0) fsm_d.wcnt = fsm_q.wcnt - 1'b1;
        if (accept) begin
            unique case (fsm_q.st)
                PS_D0: begin
                    if (req == PS_D3HOT) fsm_d.st = PS_D3HOT;
                end
                PS_D3HOT: begin
                    if (req == PS_D0) begin
                        fsm_d.st   = PS_D0;
                        fsm_d.wcnt = WLEN;
                    end
                end
                default: fsm_d.st = PS_D0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= '{st: PS_D0, wcnt: '0};
        else         fsm_q <= fsm_d;
    end

    assign pstate_o   = fsm_q.st;
    assign wake_rst_o = (fsm_q.wcnt != '0);
endmodule

// File: rtl/brg_sclk_gate.sv
module brg_sclk_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic phase_low_i,
    output logic en_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (phase_low_i) en_d = run_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/brg_pwr_rst_ctrl.sv
module brg_pwr_rst_ctrl
    import brg_pwr_pkg::*;
#(
    parameter int NUM_SEC_CLK = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HOLDOFF     = 16,
    parameter int WAKE_LEN    = 4
) (
    input  logic                   clk_i,
    input  logic                   prst_ni,
    input  logic                   clk_stop_en_i,
    input  logic [NUM_SEC_CLK-1:0] sec_clk_lo_i,
    input  logic                   cfg_wr_i,
    input  logic [1:0]             cfg_wdata_i,
    output logic [1:0]             pstate_o,
    output logic [NUM_SEC_CLK-1:0] sec_clk_en_o,
    output logic                   bus_oe_o,
    output logic                   sec_bus_rst_o,
    output logic                   int_rst_o,
    output logic                   cfg_ready_o
);
    logic    rst_n;
    logic    ready;
    logic    wake;
    logic    run;
    pstate_e st;

    brg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .arst_ni (prst_ni),
        .rst_no  (rst_n)
    );

    brg_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .ready_o (ready)
    );

    brg_pstate_fsm #(.WAKE_LEN(WAKE_LEN)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_n),
        .ready_i    (ready),
        .wr_i       (cfg_wr_i),
        .wdata_i    (cfg_wdata_i),
        .pstate_o   (st),
        .wake_rst_o (wake)
    );

    assign run = !(is_sleep(st) && clk_stop_en_i);

    for (genvar i = 0; i < NUM_SEC_CLK; i++) begin : g_gate
        brg_sclk_gate u_gate (
            .clk_i       (clk_i),
            .rst_ni      (rst_n),
            .run_i       (run),
            .phase_low_i (sec_clk_lo_i[i]),
            .en_o        (sec_clk_en_o[i])
        );
    end

    assign pstate_o      = st;
    assign bus_oe_o      = rst_n;
    assign sec_bus_rst_o = !rst_n;
    assign int_rst_o     = wake;
    assign cfg_ready_o   = ready;
endmodule

// File: rtl/brg_pwr_rst_ctrl_chk.sv
module brg_pwr_rst_ctrl_chk #(
    parameter int NUM_SEC_CLK = 2
) (
    input logic                   clk_i,
    input logic                   prst_ni,
    input logic [NUM_SEC_CLK-1:0] sec_clk_lo_i,
    input logic                   cfg_wr_i,
    input logic [1:0]             cfg_wdata_i,
    input logic [1:0]             pstate_o,
    input logic [NUM_SEC_CLK-1:0] sec_clk_en_o,
    input logic                   bus_oe_o,
    input logic                   sec_bus_rst_o,
    input logic                   int_rst_o,
    input logic                   cfg_ready_o
);
    AST_PSTATE_LEGAL: assert property (@(posedge clk_i) disable iff (!prst_ni)
        (pstate_o == 2'b00 || pstate_o == 2'b11)); // R1

    AST_MID_CODES_DROPPED: assert property (@(posedge clk_i) disable iff (!prst_ni)
        (cfg_wr_i && (cfg_wdata_i == 2'b01 || cfg_wdata_i == 2'b10)) |=> $stable(pstate_o)); // R1

    AST_WAKE_PULSES: assert property (@(posedge clk_i) disable iff (!prst_ni)
        (pstate_o == 2'b00 && $past(pstate_o) == 2'b11) |-> int_rst_o); // R5

    AST_WAKE_NO_SBRST: assert property (@(posedge clk_i) disable iff (!prst_ni)
        int_rst_o |-> !sec_bus_rst_o); // R6

    AST_RESET_HIGHZ: assert property (@(posedge clk_i)
        !prst_ni |-> (!bus_oe_o && sec_bus_rst_o && !cfg_ready_o)); // R7

    AST_LOCKED_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!prst_ni)
        (cfg_wr_i && !cfg_ready_o) |=> $stable(pstate_o)); // R8

    AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!prst_ni)
        cfg_ready_o |=> cfg_ready_o); // R8

    AST_LOCKED_IN_WAKE: assert property (@(posedge clk_i) disable iff (!prst_ni)
        (cfg_wr_i && int_rst_o) |=> $stable(pstate_o)); // R9

    for (genvar i = 0; i < NUM_SEC_CLK; i++) begin : g_chk
        AST_GATE_IN_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!prst_ni)
            !sec_clk_lo_i[i] |=> $stable(sec_clk_en_o[i])); // R4
    end
endmodule

bind brg_pwr_rst_ctrl brg_pwr_rst_ctrl_chk #(.NUM_SEC_CLK(NUM_SEC_CLK)) u_chk (
    .clk_i         (clk_i),
    .prst_ni       (prst_ni),
    .sec_clk_lo_i  (sec_clk_lo_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .pstate_o      (pstate_o),
    .sec_clk_en_o  (sec_clk_en_o),
    .bus_oe_o      (bus_oe_o),
    .sec_bus_rst_o (sec_bus_rst_o),
    .int_rst_o     (int_rst_o),
    .cfg_ready_o   (cfg_ready_o)
);

// File: tb/brg_pwr_rst_ctrl_tb.sv
`timescale 1ns/1ps
module brg_pwr_rst_ctrl_tb;
    localparam int N        = 2;
    localparam int WAKE_LEN = 4;
    localparam int HOLDOFF  = 16;

    logic         clk = 1'b0;
    logic         prst_ni;
    logic         clk_stop_en_i;
    logic [N-1:0] sec_clk_lo_i;
    logic         cfg_wr_i;
    logic [1:0]   cfg_wdata_i;
    logic [1:0]   pstate_o;
    logic [N-1:0] sec_clk_en_o;
    logic         bus_oe_o, sec_bus_rst_o, int_rst_o, cfg_ready_o;

    int checks = 0;
    int fails  = 0;

    // bench model for the random phase
    logic [1:0]   m_st;
    int           m_wcnt;
    logic [N-1:0] m_en;

    always #2 clk = ~clk;

    brg_pwr_rst_ctrl #(.NUM_SEC_CLK(N), .HOLDOFF(HOLDOFF), .WAKE_LEN(WAKE_LEN)) u_dut (
        .clk_i(clk), .prst_ni(prst_ni), .clk_stop_en_i(clk_stop_en_i),
        .sec_clk_lo_i(sec_clk_lo_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .pstate_o(pstate_o), .sec_clk_en_o(sec_clk_en_o), .bus_oe_o(bus_oe_o),
        .sec_bus_rst_o(sec_bus_rst_o), .int_rst_o(int_rst_o), .cfg_ready_o(cfg_ready_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] next_state(input logic [1:0] st, input logic [1:0] wd);
        if (st == 2'b00 && wd == 2'b11) return 2'b11;
        if (st == 2'b11 && wd == 2'b00) return 2'b00;
        return st;
    endfunction

    task automatic write_req(input logic [1:0] wd);
        cfg_wr_i    = 1'b1;
        cfg_wdata_i = wd;
        @(negedge clk);
        cfg_wr_i    = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 64 && !cfg_ready_o; k++) @(negedge clk);
    endtask

    task automatic model_step(input logic wr, input logic [1:0] wd,
                              input logic strap, input logic [N-1:0] lo);
        logic         run;
        logic [1:0]   st_n;
        int           w_n;
        run  = !(m_st == 2'b11 && strap);
        for (int i = 0; i < N; i++) if (lo[i]) m_en[i] = run;
        st_n = m_st;
        w_n  = (m_wcnt > 0) ? m_wcnt - 1 : 0;
        if (wr && m_wcnt == 0) begin
            st_n = next_state(m_st, wd);
            if (m_st == 2'b11 && st_n == 2'b00) w_n = WAKE_LEN;
        end
        m_st   = st_n;
        m_wcnt = w_n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        prst_ni = 1'b0; clk_stop_en_i = 1'b1; sec_clk_lo_i = '1;
        cfg_wr_i = 1'b0; cfg_wdata_i = 2'b00;
        repeat (3) @(negedge clk);
        check("R7 reset oe", int'(bus_oe_o), 0);
        check("R7 reset sbrst", int'(sec_bus_rst_o), 1);
        check("R7 reset ready", int'(cfg_ready_o), 0);
        check("R7 reset state", int'(pstate_o), 0);
        check("R7 reset enables", int'(sec_clk_en_o), (1 << N) - 1);

        // R8: release between edges, write held through hold-off
        cfg_wr_i = 1'b1; cfg_wdata_i = 2'b11;
        #1 prst_ni = 1'b1;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); n++;
            #1;
            if (cfg_ready_o) break;
        end
        check("R8 holdoff edges", n, HOLDOFF + 2);
        @(negedge clk);
        cfg_wr_i = 1'b0;
        check("R8 write before ready dropped", int'(pstate_o), 0);
        check("R6 sbrst released", int'(sec_bus_rst_o), 0);

        // R1: middle codes in full power
        write_req(2'b01);
        check("R1 code 01 in D0", int'(pstate_o), 0);
        write_req(2'b10);
        check("R1 code 10 in D0", int'(pstate_o), 0);

        // R2/R3: enter low power with strap set
        write_req(2'b11);
        check("R2 enter sleep", int'(pstate_o), 3);
        check("R3 enable still on at entry edge", int'(sec_clk_en_o), (1 << N) - 1);
        @(negedge clk);
        check("R3 clocks stopped", int'(sec_clk_en_o), 0);
        write_req(2'b01);
        check("R1 code 01 in sleep", int'(pstate_o), 3);
        write_req(2'b10);
        check("R1 code 10 in sleep", int'(pstate_o), 3);

        // R5/R6/R9: wake pulse
        write_req(2'b00);
        check("R2 wake state", int'(pstate_o), 0);
        n = 0;
        for (int k = 0; k < 20 && int_rst_o; k++) begin
            n++;
            if (sec_bus_rst_o) check("R6 sbrst during wake", 1, 0);
            cfg_wr_i    = (k == 1);
            cfg_wdata_i = 2'b11;
            @(negedge clk);
        end
        cfg_wr_i = 1'b0;
        check("R5 wake pulse length", n, WAKE_LEN);
        check("R9 write in wake dropped", int'(pstate_o), 0);
        check("R5 clocks restarted", int'(sec_clk_en_o), (1 << N) - 1);

        // R3: strap low keeps clocks running
        clk_stop_en_i = 1'b0;
        write_req(2'b11);
        repeat (3) @(negedge clk);
        check("R3 strap low keeps clocks", int'(sec_clk_en_o), (1 << N) - 1);
        write_req(2'b00);
        repeat (WAKE_LEN + 1) @(negedge clk);

        // R4: stop waits for the low phase of each clock
        clk_stop_en_i = 1'b1; sec_clk_lo_i = '0;
        write_req(2'b11);
        repeat (3) @(negedge clk);
        check("R4 no phase, no change", int'(sec_clk_en_o), (1 << N) - 1);
        sec_clk_lo_i = 1;
        @(negedge clk);
        check("R4 only clock 0 stopped", int'(sec_clk_en_o), ((1 << N) - 1) & ~1);

        // R7: asynchronous reset mid-run
        #1 prst_ni = 1'b0;
        #1;
        check("R7 async oe", int'(bus_oe_o), 0);
        check("R7 async sbrst", int'(sec_bus_rst_o), 1);
        check("R7 async state", int'(pstate_o), 0);
        check("R7 async enables", int'(sec_clk_en_o), (1 << N) - 1);
        check("R7 async ready", int'(cfg_ready_o), 0);
        repeat (3) @(negedge clk);
        prst_ni = 1'b1;
        sec_clk_lo_i = '1;
        wait_ready();
        check("R8 ready again", int'(cfg_ready_o), 1);

        // random phase against bench model (R2 R3 R4 R5 R9)
        m_st = 2'b00; m_wcnt = 0; m_en = '1;
        for (int it = 0; it < 3000; it++) begin
            logic         wr, strap;
            logic [1:0]   wd;
            logic [N-1:0] lo;
            check("R2 random state", int'(pstate_o), int'(m_st));
            check("R5 random pulse", int'(int_rst_o), int'(m_wcnt > 0));
            check("R4 random enables", int'(sec_clk_en_o), int'(m_en));
            wr    = ($urandom % 3) == 0;
            wd    = 2'($urandom);
            strap = ($urandom % 16) == 0 ? !clk_stop_en_i : clk_stop_en_i;
            lo    = N'($urandom);
            cfg_wr_i = wr; cfg_wdata_i = wd; clk_stop_en_i = strap; sec_clk_lo_i = lo;
            @(posedge clk);
            model_step(wr, wd, strap, lo);
            @(negedge clk);
        end
        cfg_wr_i = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule